// File: doc/BRIEF.md
# Window Watchdog and Reset Supervisor with Fail-Safe Output

This block supervises a host processor. It holds a reset output low after the supply comes good. It then expects the host to service a window watchdog by writing an 8-bit control word over SPI. The word is taken in when chip select returns high, and bit 0 of that word is the trigger. All timing is counted in pulses of a slow time-base tick, which nominally runs at about 0.51 ms per pulse.

After the power-on delay, a long open window gives the host time to start. The first service is a 0-to-1 change of bit 0. Each accepted service starts a closed window, followed by an open window. Every later service must invert bit 0, and it must arrive in the open window. A service that comes too early, or one that never comes, produces a short watchdog reset pulse, after which the long window starts again. A fail-safe output rises only once the host has serviced the watchdog correctly four times. A sticky diagnosis bit shows that a watchdog reset has happened, or that power-up has occurred, and no service has been accepted since.

The watchdog can be suspended in three cases: by a sleep input, by a flash-programming input, or in standby when control bit 7 is set and the load current is low. When it resumes, it starts with a long open window.

Top module: `wdg_supervisor`

## Requirements
- R1: While `vcc_ok` is low, `wd_rst_n` and `fail_safe` are low, `wd_diag` is high and `ctrl_bits` is 0.
- R2: After `vcc_ok` rises, `wd_rst_n` stays low for 15 time-base ticks and goes high on the 16th.
- R3: Release of reset opens a long window of 128 ticks. If no trigger arrives in it, `wd_rst_n` falls on the 128th tick.
- R4: A watchdog reset pulse lasts 4 ticks. `wd_rst_n` then rises and a new long window starts.
- R5: A rising edge on `spi_csn` copies `spi_word` into `ctrl_bits`. In the long window, only a change of bit 0 from 0 to 1 is a trigger, so a word with bit 0 at 0 there does not clear `wd_diag`.
- R6: An accepted trigger starts a closed window of 12 ticks. A word that inverts bit 0 within those 12 ticks (even after 11) causes an immediate watchdog reset.
- R7: The open window of 20 ticks follows the closed window. A word that inverts bit 0 is a service and restarts the closed window. A word that leaves bit 0 unchanged is not a service. Without a service, `wd_rst_n` falls on the 20th tick.
- R8: Every watchdog reset clears `ctrl_bits` to 0, drives `fail_safe` low and sets `wd_diag`. Any accepted trigger clears `wd_diag`.
- R9: `fail_safe` rises on the 4th accepted trigger since the last reset. The trigger in the long window counts as the first.
- R10: While `flash_mode` or `sleep_mode` is high, no watchdog reset occurs. On release, a full long window of 128 ticks starts.
- R11: `standby_mode`, `load_low` and `ctrl_bits[7]` all high suspend the watchdog. When any of the three goes low, a full long window starts. With bit 7 clear, the watchdog keeps running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| vcc_ok | input | 1 | Regulator above reset threshold; low acts as asynchronous undervoltage reset |
| tick_in | input | 1 | Time-base pulse (one clock wide) |
| spi_csn | input | 1 | SPI chip select, active low |
| spi_word | input | 8 | Control word shifted in by the SPI block |
| sleep_mode | input | 1 | Sleep mode active |
| flash_mode | input | 1 | Flash-programming mode active |
| standby_mode | input | 1 | Standby mode active |
| load_low | input | 1 | Regulator load current below threshold |
| ctrl_bits | output | 8 | Current control word |
| wd_rst_n | output | 1 | Reset to host, active low |
| fail_safe | output | 1 | High after four correct services |
| wd_diag | output | 1 | Sticky watchdog-reset diagnosis |

## Verification
The service sequence is driven with alternating words at the exact boundary ticks, so the bench can tell whether a window is counted one tick short or one tick long. The open window is also offered a word with bit 0 unchanged, which separates real inversion detection from a response to any chip-select edge. In the closed window, a toggle after 11 ticks shows that early detection covers the whole closed window. The three suspend sources are each held for longer than any window and then released, which checks that a full long window restarts afterwards. A standby case with bit 7 clear shows that the undercurrent suspend needs all three of its conditions.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
   typedef enum logic [2:0] {
      WS_POR    = 3'd0,
      WS_LONG   = 3'd1,
      WS_CLOSED = 3'd2,
      WS_OPEN   = 3'd3,
      WS_PULSE  = 3'd4,
      WS_OFF    = 3'd5
   } wdg_state_e;

   localparam int TRIG_BIT = 0;
   localparam int UC_BIT   = 7;

   function automatic int max_of5(input int a, input int b, input int c,
                                  input int d, input int e);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      if (e > m) m = e;
      return m;
   endfunction
endpackage

// File: rtl/wdg_tick_cond.sv
module wdg_tick_cond #(
   parameter bit TICK_IS_LEVEL = 1'b0
) (
   input  logic clk,
   input  logic vcc_ok,
   input  logic tick_in,
   output logic tick
);
   logic stage1_q;

   always_ff @(posedge clk or negedge vcc_ok) begin
      if (!vcc_ok) stage1_q <= 1'b0;
      else         stage1_q <= tick_in;
   end

   generate
      if (TICK_IS_LEVEL) begin : g_level
         logic stage2_q;
         always_ff @(posedge clk or negedge vcc_ok) begin
            if (!vcc_ok) stage2_q <= 1'b0;
            else         stage2_q <= stage1_q;
         end
         assign tick = stage1_q & ~stage2_q;
      end else begin : g_pulse
         assign tick = stage1_q;
      end
   endgenerate
endmodule

// File: rtl/wdg_spi_capture.sv
module wdg_spi_capture #(
   parameter int CTRL_W = 8
) (
   input  logic              clk,
   input  logic              vcc_ok,
   input  logic              spi_csn,
   input  logic [CTRL_W-1:0] spi_word,
   input  logic              clr,
   output logic [CTRL_W-1:0] ctrl_q,
   output logic              trig_rise,
   output logic              trig_toggle
);
   import wdg_pkg::*;

   logic csn_q;
   logic cs_rise;

   always_ff @(posedge clk or negedge vcc_ok) begin
      if (!vcc_ok) csn_q <= 1'b1;
      else         csn_q <= spi_csn;
   end

   assign cs_rise     = spi_csn & ~csn_q;
   assign trig_rise   = cs_rise & spi_word[TRIG_BIT] & ~ctrl_q[TRIG_BIT];
   assign trig_toggle = cs_rise & (spi_word[TRIG_BIT] ^ ctrl_q[TRIG_BIT]);

   always_ff @(posedge clk or negedge vcc_ok) begin
      if (!vcc_ok)      ctrl_q <= '0;
      else if (clr)     ctrl_q <= '0;
      else if (cs_rise) ctrl_q <= spi_word;
   end
endmodule

// File: rtl/wdg_window_fsm.sv
module wdg_window_fsm #(
   parameter int POR_TICKS    = 16,
   parameter int LONG_TICKS   = 128,
   parameter int CLOSED_TICKS = 12,
   parameter int OPEN_TICKS   = 20,
   parameter int PULSE_TICKS  = 4,
   parameter int CNT_W        = 8
) (
   input  logic clk,
   input  logic vcc_ok,
   input  logic tick,
   input  logic trig_rise,
   input  logic trig_toggle,
   input  logic wd_off,
   output logic rst_n,
   output logic enter_pulse,
   output logic good_svc
);
   import wdg_pkg::*;

   localparam logic [CNT_W-1:0] POR_END    = CNT_W'(POR_TICKS - 1);
   localparam logic [CNT_W-1:0] LONG_END   = CNT_W'(LONG_TICKS - 1);
   localparam logic [CNT_W-1:0] CLOSED_END = CNT_W'(CLOSED_TICKS - 1);
   localparam logic [CNT_W-1:0] OPEN_END   = CNT_W'(OPEN_TICKS - 1);
   localparam logic [CNT_W-1:0] PULSE_END  = CNT_W'(PULSE_TICKS - 1);

   wdg_state_e       st_q, st_d;
   logic [CNT_W-1:0] cnt_q;

   always_comb begin
      st_d     = st_q;
      good_svc = 1'b0;
      if (st_q == WS_POR) begin
         if (tick && cnt_q == POR_END) st_d = WS_LONG;
      end else if (wd_off) begin
         st_d = WS_OFF;
      end else begin
         case (st_q)
            WS_OFF:  st_d = WS_LONG;
            WS_LONG: begin
               if (trig_rise) begin
                  st_d     = WS_CLOSED;
                  good_svc = 1'b1;
               end else if (tick && cnt_q == LONG_END) begin
                  st_d = WS_PULSE;
               end
            end
            WS_CLOSED: begin
               if (trig_toggle)                     st_d = WS_PULSE;
               else if (tick && cnt_q == CLOSED_END) st_d = WS_OPEN;
            end
            WS_OPEN: begin
               if (trig_toggle) begin
                  st_d     = WS_CLOSED;
                  good_svc = 1'b1;
               end else if (tick && cnt_q == OPEN_END) begin
                  st_d = WS_PULSE;
               end
            end
            WS_PULSE: begin
               if (tick && cnt_q == PULSE_END) st_d = WS_LONG;
            end
            default: st_d = WS_POR;
         endcase
      end
   end

   assign enter_pulse = (st_d == WS_PULSE) && (st_q != WS_PULSE);

   always_ff @(posedge clk or negedge vcc_ok) begin
      if (!vcc_ok) begin
         st_q  <= WS_POR;
         cnt_q <= '0;
      end else begin
         st_q <= st_d;
         if (st_d != st_q)                cnt_q <= '0;
         else if (tick && st_q != WS_OFF) cnt_q <= cnt_q + 1'b1;
      end
   end

   assign rst_n = !((st_q == WS_POR) || (st_q == WS_PULSE));
endmodule

// File: rtl/wdg_failsafe.sv
module wdg_failsafe #(
   parameter int FS_SERVICES = 4
) (
   input  logic clk,
   input  logic vcc_ok,
   input  logic enter_pulse,
   input  logic good_svc,
   output logic fail_safe,
   output logic wd_diag
);
   localparam int SVC_W = $clog2(FS_SERVICES + 1);
   localparam logic [SVC_W-1:0] SVC_LAST = SVC_W'(FS_SERVICES - 1);

   logic [SVC_W-1:0] svc_q;

   always_ff @(posedge clk or negedge vcc_ok) begin
      if (!vcc_ok) begin
         svc_q     <= '0;
         fail_safe <= 1'b0;
         wd_diag   <= 1'b1;
      end else if (enter_pulse) begin
         svc_q     <= '0;
         fail_safe <= 1'b0;
         wd_diag   <= 1'b1;
      end else if (good_svc) begin
         wd_diag <= 1'b0;
         if (!fail_safe) begin
            if (svc_q == SVC_LAST) fail_safe <= 1'b1;
            else                   svc_q     <= svc_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/wdg_supervisor.sv
module wdg_supervisor #(
   parameter int CTRL_W       = 8,
   parameter int POR_TICKS    = 16,
   parameter int LONG_TICKS   = 128,
   parameter int CLOSED_TICKS = 12,
   parameter int OPEN_TICKS   = 20,
   parameter int PULSE_TICKS  = 4,
   parameter int FS_SERVICES  = 4,
   parameter bit TICK_IS_LEVEL = 1'b0
) (
   input  logic              clk,
   input  logic              vcc_ok,
   input  logic              tick_in,
   input  logic              spi_csn,
   input  logic [CTRL_W-1:0] spi_word,
   input  logic              sleep_mode,
   input  logic              flash_mode,
   input  logic              standby_mode,
   input  logic              load_low,
   output logic [CTRL_W-1:0] ctrl_bits,
   output logic              wd_rst_n,
   output logic              fail_safe,
   output logic              wd_diag
);
   import wdg_pkg::*;

   localparam int CNT_W = $clog2(max_of5(POR_TICKS, LONG_TICKS, CLOSED_TICKS,
                                         OPEN_TICKS, PULSE_TICKS) + 1);

   initial begin
      assert (CTRL_W > UC_BIT) else $error("CTRL_W must cover the undercurrent bit");
      assert (POR_TICKS > 0 && LONG_TICKS > 0 && CLOSED_TICKS > 0 &&
              OPEN_TICKS > 0 && PULSE_TICKS > 0) else $error("window lengths must be positive");
      assert (FS_SERVICES > 0) else $error("FS_SERVICES must be positive");
   end

   logic tick;
   logic trig_rise, trig_toggle;
   logic enter_pulse, good_svc;
   logic ctrl_clr;
   logic wd_off;

   wdg_tick_cond #(.TICK_IS_LEVEL(TICK_IS_LEVEL)) u_tick (
      .clk(clk), .vcc_ok(vcc_ok), .tick_in(tick_in), .tick(tick)
   );

   assign ctrl_clr = enter_pulse | ~wd_rst_n;

   wdg_spi_capture #(.CTRL_W(CTRL_W)) u_cap (
      .clk(clk), .vcc_ok(vcc_ok), .spi_csn(spi_csn), .spi_word(spi_word),
      .clr(ctrl_clr), .ctrl_q(ctrl_bits),
      .trig_rise(trig_rise), .trig_toggle(trig_toggle)
   );

   assign wd_off = sleep_mode | flash_mode |
                   (standby_mode & load_low & ctrl_bits[UC_BIT]);

   wdg_window_fsm #(
      .POR_TICKS(POR_TICKS), .LONG_TICKS(LONG_TICKS),
      .CLOSED_TICKS(CLOSED_TICKS), .OPEN_TICKS(OPEN_TICKS),
      .PULSE_TICKS(PULSE_TICKS), .CNT_W(CNT_W)
   ) u_fsm (
      .clk(clk), .vcc_ok(vcc_ok), .tick(tick),
      .trig_rise(trig_rise), .trig_toggle(trig_toggle), .wd_off(wd_off),
      .rst_n(wd_rst_n), .enter_pulse(enter_pulse), .good_svc(good_svc)
   );

   wdg_failsafe #(.FS_SERVICES(FS_SERVICES)) u_fs (
      .clk(clk), .vcc_ok(vcc_ok), .enter_pulse(enter_pulse),
      .good_svc(good_svc), .fail_safe(fail_safe), .wd_diag(wd_diag)
   );
endmodule

// File: rtl/wdg_supervisor_checker.sv
module wdg_supervisor_checker #(
   parameter int CTRL_W = 8
) (
   input logic              clk,
   input logic              vcc_ok,
   input logic              flash_mode,
   input logic [CTRL_W-1:0] ctrl_bits,
   input logic              wd_rst_n,
   input logic              fail_safe,
   input logic              wd_diag
);
   assert_fs_rises_in_run_R9: assert property (@(posedge clk) disable iff (!vcc_ok)
      $rose(fail_safe) |-> wd_rst_n);

   assert_fs_low_in_reset_R1: assert property (@(posedge clk) disable iff (!vcc_ok)
      !wd_rst_n |-> !fail_safe);

   assert_pulse_sets_diag_R8: assert property (@(posedge clk) disable iff (!vcc_ok)
      $fell(wd_rst_n) |-> wd_diag);

   assert_pulse_clears_ctrl_R8: assert property (@(posedge clk) disable iff (!vcc_ok)
      $fell(wd_rst_n) |-> (ctrl_bits == '0));

   assert_diag_rises_with_pulse_R8: assert property (@(posedge clk) disable iff (!vcc_ok)
      $rose(wd_diag) |-> !wd_rst_n);

   assert_flash_holds_run_R10: assert property (@(posedge clk) disable iff (!vcc_ok)
      (flash_mode && wd_rst_n) |=> wd_rst_n);
endmodule

bind wdg_supervisor wdg_supervisor_checker #(.CTRL_W(CTRL_W)) u_chk (
   .clk(clk), .vcc_ok(vcc_ok), .flash_mode(flash_mode), .ctrl_bits(ctrl_bits),
   .wd_rst_n(wd_rst_n), .fail_safe(fail_safe), .wd_diag(wd_diag)
);

// File: tb/wdg_supervisor_test.sv
module wdg_supervisor_test;
   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic       vcc_ok = 1'b0, tick_in = 1'b0, spi_csn = 1'b1;
   logic [7:0] spi_word = 8'h00;
   logic       sleep_mode = 1'b0, flash_mode = 1'b0, standby_mode = 1'b0, load_low = 1'b0;
   logic [7:0] ctrl_bits;
   logic       wd_rst_n, fail_safe, wd_diag;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   wdg_supervisor uut (
      .clk(clk), .vcc_ok(vcc_ok), .tick_in(tick_in), .spi_csn(spi_csn),
      .spi_word(spi_word), .sleep_mode(sleep_mode), .flash_mode(flash_mode),
      .standby_mode(standby_mode), .load_low(load_low), .ctrl_bits(ctrl_bits),
      .wd_rst_n(wd_rst_n), .fail_safe(fail_safe), .wd_diag(wd_diag)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         tick_in = 1'b1;
         @(negedge clk);
         tick_in = 1'b0;
         repeat (3) @(negedge clk);
      end
   endtask

   task automatic spi_write(input logic [7:0] w);
      spi_word = w;
      spi_csn  = 1'b0;
      @(negedge clk);
      spi_csn = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   task automatic t_reset_state;
      vcc_ok = 1'b0;
      repeat (4) @(negedge clk);
      chk("R1", "rst_n", 32'(wd_rst_n), 0);
      chk("R1", "fail_safe", 32'(fail_safe), 0);
      chk("R1", "diag", 32'(wd_diag), 1);
      chk("R1", "ctrl", 32'(ctrl_bits), 0);
      vcc_ok = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_power_on;
      ticks(15);
      chk("R2", "rst_n after 15", 32'(wd_rst_n), 0);
      ticks(1);
      chk("R2", "rst_n after 16", 32'(wd_rst_n), 1);
   endtask

   task automatic t_long_timeout;
      ticks(127);
      chk("R3", "rst_n after 127", 32'(wd_rst_n), 1);
      ticks(1);
      chk("R3", "rst_n after 128", 32'(wd_rst_n), 0);
      chk("R8", "diag on pulse", 32'(wd_diag), 1);
      ticks(3);
      chk("R4", "pulse after 3", 32'(wd_rst_n), 0);
      ticks(1);
      chk("R4", "pulse after 4", 32'(wd_rst_n), 1);
   endtask

   task automatic t_services;
      spi_write(8'h00);
      chk("R5", "bit0 low no trigger", 32'(wd_diag), 1);
      spi_write(8'h41);
      chk("R5", "ctrl captured", 32'(ctrl_bits), 32'h41);
      chk("R8", "diag cleared", 32'(wd_diag), 0);
      ticks(12);
      spi_write(8'h40);
      ticks(12);
      spi_write(8'h41);
      chk("R9", "fs after 3", 32'(fail_safe), 0);
      ticks(12);
      spi_write(8'h40);
      chk("R9", "fs after 4", 32'(fail_safe), 1);
      chk("R7", "run after services", 32'(wd_rst_n), 1);
   endtask

   task automatic t_open_timeout;
      ticks(12);
      spi_write(8'h40);
      ticks(19);
      chk("R7", "open after 19", 32'(wd_rst_n), 1);
      ticks(1);
      chk("R7", "open after 20", 32'(wd_rst_n), 0);
      chk("R8", "fs cleared", 32'(fail_safe), 0);
      chk("R8", "ctrl cleared", 32'(ctrl_bits), 0);
      chk("R8", "diag set", 32'(wd_diag), 1);
      ticks(4);
   endtask

   task automatic t_early;
      spi_write(8'h01);
      ticks(11);
      chk("R6", "closed still running", 32'(wd_rst_n), 1);
      spi_write(8'h00);
      chk("R6", "early toggle resets", 32'(wd_rst_n), 0);
      chk("R6", "ctrl cleared", 32'(ctrl_bits), 0);
      ticks(4);
   endtask

   task automatic t_flash_sleep;
      flash_mode = 1'b1;
      ticks(200);
      chk("R10", "flash no reset", 32'(wd_rst_n), 1);
      flash_mode = 1'b0;
      ticks(127);
      chk("R10", "long after flash 127", 32'(wd_rst_n), 1);
      ticks(1);
      chk("R10", "long after flash 128", 32'(wd_rst_n), 0);
      ticks(4);
      sleep_mode = 1'b1;
      ticks(200);
      chk("R10", "sleep no reset", 32'(wd_rst_n), 1);
      sleep_mode = 1'b0;
      ticks(127);
      chk("R10", "long after sleep 127", 32'(wd_rst_n), 1);
      ticks(1);
      chk("R10", "long after sleep 128", 32'(wd_rst_n), 0);
      ticks(4);
   endtask

   task automatic t_undercurrent;
      standby_mode = 1'b1;
      load_low     = 1'b1;
      spi_write(8'h80);
      chk("R11", "bit7 captured", 32'(ctrl_bits), 32'h80);
      ticks(200);
      chk("R11", "suspended", 32'(wd_rst_n), 1);
      load_low = 1'b0;
      ticks(127);
      chk("R11", "long after resume 127", 32'(wd_rst_n), 1);
      ticks(1);
      chk("R11", "long after resume 128", 32'(wd_rst_n), 0);
      ticks(4);
      load_low = 1'b1;
      ticks(127);
      chk("R11", "bit7 clear runs 127", 32'(wd_rst_n), 1);
      ticks(1);
      chk("R11", "bit7 clear runs 128", 32'(wd_rst_n), 0);
      ticks(4);
      standby_mode = 1'b0;
      load_low     = 1'b0;
   endtask

   task automatic t_undervoltage;
      spi_write(8'h41);
      ticks(12);
      spi_write(8'h40);
      ticks(12);
      spi_write(8'h41);
      ticks(12);
      spi_write(8'h40);
      chk("R9", "fs before drop", 32'(fail_safe), 1);
      vcc_ok = 1'b0;
      #1;
      chk("R1", "rst_n on drop", 32'(wd_rst_n), 0);
      chk("R1", "fs on drop", 32'(fail_safe), 0);
      chk("R1", "diag on drop", 32'(wd_diag), 1);
      chk("R1", "ctrl on drop", 32'(ctrl_bits), 0);
   endtask

   initial begin
      t_reset_state();
      t_power_on();
      t_long_timeout();
      t_services();
      t_open_timeout();
      t_early();
      t_flash_sleep();
      t_undercurrent();
      t_undervoltage();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule